// File: doc/BRIEF.md
# Clause Row with Unit Propagation

This block is one row of a hardware satisfiability engine: a single clause over `N` variables, held as one literal cell per variable plus a termination stage at the end of the row. Each cell stores a two-bit code saying whether its variable is missing from the clause, appears plain, or appears negated. Each cell watches that variable's three-wire bus (`lit`, `lit_bar`, `implied`). The row then works out whether the clause is already true and how many of its literals are still open. That count saturates at two.

When the clause is false except for a single open literal, the row raises an implication drive. The open cell then pushes its own polarity onto its variable's bus and flags the value as implied. When no open literal is left and the clause is still false, the row raises a conflict drive. It also does so when it is forcing an implication and one of its variables already shows a conflict. Under a conflict drive, every cell puts its stored code onto the bus, so the engine can gather the literals of the learned clause.

The row's drive outputs are its own share of each bus. The surrounding array ORs the shares of all rows together, so two rows implying opposite values give `lit = lit_bar = 1`. A write strobe loads the whole clause in one clock.

Top module: `clause_row`

## Requirements
- R1: On a rising clock edge with `wrEn` high, cell i loads `wrCode[2i+1:2i]`: 2'b10 is a plain literal, 2'b01 a negated literal, 2'b00 absent, and 2'b11 is stored as absent. With `wrEn` low the codes hold. An active-low `rstN` clears all codes to absent.
- R2: The variable bus `{lit,lit_bar,implied}` reads 000 free, 010 / 100 assigned 0 / 1, 011 / 101 implied 0 / 1, 111 conflict and 110 member of the learned clause. Assigned and implied values are treated alike when the row judges satisfaction.
- R3: `freeCnt` counts the participating cells whose variable has `lit = lit_bar = 0`. It saturates at 2'b10, which means two or more.
- R4: `clauseSat` is high exactly when some participating cell sees `{lit,lit_bar}` equal to its stored code.
- R5: `impDrv` is high exactly when the clause is unsatisfied and `freeCnt` is 2'b01. The single open cell then raises its `drvImp` bit and drives its code on `drvLit`/`drvLitBar`.
- R6: `ccDrv` is high whenever the clause is unsatisfied and `freeCnt` is 0.
- R7: `ccDrv` is also high when `impDrv` is high and a participating variable's bus reads 111. A conflict bus alone, with `impDrv` low, raises nothing.
- R8: While `ccDrv` is high, every cell drives its stored code on `drvLit`/`drvLitBar`. `drvImp` stays limited to the open cell under `impDrv`.
- R9: With both `impDrv` and `ccDrv` low, all drive outputs are zero.
- R10: After reset the row holds no literal, so it reads unsatisfied with `freeCnt` 0 and `ccDrv` high, and drives zero on `drvImp`.
- R11: The bus value of a variable that is absent from the clause affects no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the literal code registers |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load strobe for the clause codes |
| wrCode | input | 2*N | Literal codes, two bits per variable |
| busLit | input | N | `lit` wire of each variable bus |
| busLitBar | input | N | `lit_bar` wire of each variable bus |
| busImp | input | N | `implied` wire of each variable bus |
| drvLit | output | N | This row's drive onto each `lit` wire |
| drvLitBar | output | N | This row's drive onto each `lit_bar` wire |
| drvImp | output | N | This row's drive onto each `implied` wire |
| clauseSat | output | 1 | Clause currently satisfied |
| freeCnt | output | 2 | Saturating open-literal count |
| impDrv | output | 1 | Unit clause, implication being driven |
| ccDrv | output | 1 | Conflict-clause drive |

## Verification
The row is tried with all-open buses and with two open literals plus a stray open absent variable, so the saturating count and the rule that discards code 11 both show. Partial assignments that leave exactly one open literal are contrasted with one satisfying value, given once as assigned and once as implied. A fully falsifying pattern tells the ordinary conflict apart from the implication case. A 111 bus under an implication is set against the same bus with two literals open, which separates the cell-raised conflict from a quiet row. Finally the row is reloaded, and an ignored write proves that the codes are held.

// File: rtl/clause_row_pkg.sv
package clause_row_pkg;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_BOTH = 2'b11;
  localparam logic [1:0] CNT_ZERO  = 2'b00;
  localparam logic [1:0] CNT_ONE   = 2'b01;
  localparam logic [1:0] CNT_MANY  = 2'b10;

  // status the cell datapath reports to the termination control
  typedef struct packed {
    logic       sat;
    logic [1:0] freeCnt;
    logic       confSeen;
  } rowStatus_t;

  // strobes the termination control returns to the cells
  typedef struct packed {
    logic impDrv;
    logic ccDrv;
  } termStrobe_t;

  function automatic logic [1:0] satInc(input logic [1:0] cnt, input logic inc);
    if (!inc)               return cnt;
    else if (cnt == CNT_ZERO) return CNT_ONE;
    else                    return CNT_MANY;
  endfunction

endpackage

// File: rtl/clause_row_cells.sv
module clause_row_cells
  import clause_row_pkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2*N-1:0] wrCode,
  input  logic [N-1:0]  busLit,
  input  logic [N-1:0]  busLitBar,
  input  logic [N-1:0]  busImp,
  input  termStrobe_t   strobe,
  output rowStatus_t    status,
  output logic [N-1:0]  drvLit,
  output logic [N-1:0]  drvLitBar,
  output logic [N-1:0]  drvImp
);

  logic [N-1:0][1:0] code;
  logic [N:0][1:0]   cntChain;
  logic [N-1:0]      isPart;
  logic [N-1:0]      isFree;
  logic [N-1:0]      isMatch;
  logic [N-1:0]      isConf;
  logic [N-1:0]      drvEn;

  assign cntChain[0] = CNT_ZERO;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [1:0] inCode;
    assign inCode = wrCode[2*i+1:2*i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     code[i] <= CODE_NONE;
      else if (wrEn) code[i] <= (inCode == CODE_BOTH) ? CODE_NONE : inCode;
    end

    assign isPart[i]  = code[i][1] | code[i][0];
    assign isFree[i]  = isPart[i] & ~busLit[i] & ~busLitBar[i];
    assign isMatch[i] = isPart[i] & ({busLit[i], busLitBar[i]} == code[i]);
    assign isConf[i]  = isPart[i] & busLit[i] & busLitBar[i] & busImp[i];

    assign cntChain[i+1] = satInc(cntChain[i], isFree[i]);

    assign drvEn[i]     = strobe.ccDrv | (strobe.impDrv & isFree[i]);
    assign drvLit[i]    = drvEn[i] & code[i][1];
    assign drvLitBar[i] = drvEn[i] & code[i][0];
    assign drvImp[i]    = strobe.impDrv & isFree[i];
  end

  assign status.sat      = |isMatch;
  assign status.freeCnt  = cntChain[N];
  assign status.confSeen = |isConf;

endmodule

// File: rtl/clause_row_term.sv
module clause_row_term
  import clause_row_pkg::*;
(
  input  rowStatus_t  status,
  output termStrobe_t strobe
);

  logic unitRow;
  logic emptyRow;

  always_comb begin
    unitRow       = !status.sat && (status.freeCnt == CNT_ONE);
    emptyRow      = !status.sat && (status.freeCnt == CNT_ZERO);
    strobe.impDrv = unitRow;
    strobe.ccDrv  = emptyRow || (unitRow && status.confSeen);
  end

endmodule

// File: rtl/clause_row.sv
module clause_row
  import clause_row_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [2*N-1:0] wrCode,
  input  logic [N-1:0]   busLit,
  input  logic [N-1:0]   busLitBar,
  input  logic [N-1:0]   busImp,
  output logic [N-1:0]   drvLit,
  output logic [N-1:0]   drvLitBar,
  output logic [N-1:0]   drvImp,
  output logic           clauseSat,
  output logic [1:0]     freeCnt,
  output logic           impDrv,
  output logic           ccDrv
);

  rowStatus_t  status;
  termStrobe_t strobe;

  clause_row_cells #(.N(N)) u_cells (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrCode    (wrCode),
    .busLit    (busLit),
    .busLitBar (busLitBar),
    .busImp    (busImp),
    .strobe    (strobe),
    .status    (status),
    .drvLit    (drvLit),
    .drvLitBar (drvLitBar),
    .drvImp    (drvImp)
  );

  clause_row_term u_term (
    .status (status),
    .strobe (strobe)
  );

  assign clauseSat = status.sat;
  assign freeCnt   = status.freeCnt;
  assign impDrv    = strobe.impDrv;
  assign ccDrv     = strobe.ccDrv;

endmodule

// File: rtl/clause_row_chk.sv
module clause_row_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         clauseSat,
  input logic [1:0]   freeCnt,
  input logic         impDrv,
  input logic         ccDrv,
  input logic [N-1:0] drvLit,
  input logic [N-1:0] drvLitBar,
  input logic [N-1:0] drvImp
);

  // R3: the saturating count never reaches 2'b11
  a_r3_no_three: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt != 2'b11);

  // R5: an implication only comes from an unsatisfied unit row
  a_r5_unit_only: assert property (@(posedge clk) disable iff (!rstN)
    impDrv |-> (!clauseSat && freeCnt == 2'b01));

  // R5: exactly one cell flags the implied value
  a_r5_single_imp: assert property (@(posedge clk) disable iff (!rstN)
    impDrv |-> ($countones(drvImp) == 1));

  // R6: a falsified row always raises the conflict drive
  a_r6_falsified: assert property (@(posedge clk) disable iff (!rstN)
    (!clauseSat && freeCnt == 2'b00) |-> ccDrv);

  // R9: a quiet row drives nothing
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!impDrv && !ccDrv) |-> (drvLit == '0 && drvLitBar == '0 && drvImp == '0));

  // R4: a satisfied row raises neither drive
  a_r4_sat_quiet: assert property (@(posedge clk) disable iff (!rstN)
    clauseSat |-> (!impDrv && !ccDrv));

endmodule

bind clause_row clause_row_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clauseSat (clauseSat),
  .freeCnt   (freeCnt),
  .impDrv    (impDrv),
  .ccDrv     (ccDrv),
  .drvLit    (drvLit),
  .drvLitBar (drvLitBar),
  .drvImp    (drvImp)
);

// File: tb/clause_row_tb.sv
`timescale 1ns/1ps
module clause_row_tb;

  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [2*N-1:0] wrCode = '0;
  logic [N-1:0]   busLit = '0;
  logic [N-1:0]   busLitBar = '0;
  logic [N-1:0]   busImp = '0;
  logic [N-1:0]   drvLit, drvLitBar, drvImp;
  logic           clauseSat, impDrv, ccDrv;
  logic [1:0]     freeCnt;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  clause_row #(.N(N)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCode(wrCode),
    .busLit(busLit), .busLitBar(busLitBar), .busImp(busImp),
    .drvLit(drvLit), .drvLitBar(drvLitBar), .drvImp(drvImp),
    .clauseSat(clauseSat), .freeCnt(freeCnt), .impDrv(impDrv), .ccDrv(ccDrv)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic checkRow(input string tag, input logic sat, input logic [1:0] cnt,
                          input logic imp, input logic cc, input logic [N-1:0] eLit,
                          input logic [N-1:0] eBar, input logic [N-1:0] eImp);
    #1;
    chk({tag, " clauseSat"}, 32'(clauseSat), 32'(sat));
    chk({tag, " freeCnt"},   32'(freeCnt),   32'(cnt));
    chk({tag, " impDrv"},    32'(impDrv),    32'(imp));
    chk({tag, " ccDrv"},     32'(ccDrv),     32'(cc));
    chk({tag, " drvLit"},    32'(drvLit),    32'(eLit));
    chk({tag, " drvLitBar"}, 32'(drvLitBar), 32'(eBar));
    chk({tag, " drvImp"},    32'(drvImp),    32'(eImp));
  endtask

  task automatic loadClause(input logic [2*N-1:0] codes);
    @(negedge clk);
    wrCode = codes;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic setVar(input int idx, input logic [2:0] v);
    busLit[idx]    = v[2];
    busLitBar[idx] = v[1];
    busImp[idx]    = v[0];
  endtask

  task automatic clearBus();
    busLit = '0; busLitBar = '0; busImp = '0;
  endtask

  // clause: var0 plain, var2 negated, var5 plain, var7 written as 11
  localparam logic [2*N-1:0] CLAUSE_A = 16'b11_00_10_00_00_01_00_10;

  task automatic t_reset();
    checkRow("R10 reset", 1'b0, 2'b00, 1'b0, 1'b1, '0, '0, '0);
  endtask

  task automatic t_allFree();
    clearBus();
    // R3 saturation with three open literals, R9 quiet drives
    checkRow("R3 R9 all free", 1'b0, 2'b10, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_unit();
    clearBus();
    setVar(0, 3'b010);   // assigned 0, literal false
    setVar(2, 3'b100);   // assigned 1, negated literal false
    setVar(3, 3'b101);   // R11 absent variable noise
    // R1: var7 (code 11) stays absent, so only var5 is open
    checkRow("R5 R1 R11 unit", 1'b0, 2'b01, 1'b1, 1'b0,
             8'b0010_0000, 8'b0000_0000, 8'b0010_0000);
  endtask

  task automatic t_sat();
    clearBus();
    setVar(0, 3'b010);
    setVar(2, 3'b100);
    setVar(5, 3'b100);   // assigned 1 satisfies plain var5
    checkRow("R4 sat assigned", 1'b1, 2'b00, 1'b0, 1'b0, '0, '0, '0);
    clearBus();
    setVar(0, 3'b101);   // R2 implied 1 satisfies plain var0
    setVar(2, 3'b110);   // learned-clause member, not open
    checkRow("R2 R4 sat implied", 1'b1, 2'b01, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_falsified();
    clearBus();
    setVar(0, 3'b010);
    setVar(2, 3'b100);
    setVar(5, 3'b011);   // implied 0
    checkRow("R6 R8 falsified", 1'b0, 2'b00, 1'b0, 1'b1,
             8'b0010_0001, 8'b0000_0100, 8'b0000_0000);
  endtask

  task automatic t_conflict();
    clearBus();
    setVar(0, 3'b010);
    setVar(2, 3'b111);   // conflict on a participating var
    checkRow("R7 R8 conflict under imp", 1'b0, 2'b01, 1'b1, 1'b1,
             8'b0010_0001, 8'b0000_0100, 8'b0010_0000);
    clearBus();
    setVar(2, 3'b111);
    checkRow("R7 conflict without imp", 1'b0, 2'b10, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic t_reload();
    loadClause(16'b00_00_00_00_00_00_01_00);   // only var1 negated
    clearBus();
    setVar(0, 3'b100);   // R11 var0 is absent now
    checkRow("R1 reload", 1'b0, 2'b01, 1'b1, 1'b0,
             8'b0000_0000, 8'b0000_0010, 8'b0000_0010);
    @(negedge clk);
    wrCode = CLAUSE_A;   // wrEn low: must be ignored
    @(negedge clk);
    checkRow("R1 hold", 1'b0, 2'b01, 1'b1, 1'b0,
             8'b0000_0000, 8'b0000_0010, 8'b0000_0010);
    setVar(1, 3'b010);   // assigned 0 satisfies negated var1
    checkRow("R4 reload sat", 1'b1, 2'b00, 1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    loadClause(CLAUSE_A);
    t_allFree();
    t_unit();
    t_sat();
    t_falsified();
    t_conflict();
    t_reload();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule